// File: doc/BRIEF.md
# Multicast Group Hash Filter

This block decides whether the destination address of a received frame belongs to one of the multicast groups the station has joined. The six destination-address bytes arrive one per accepted cycle, the first one marked by a start strobe. A CRC-32 is accumulated over them, and an 8-bit index is taken from the result. That index picks one bit in a 256-entry table. The table is held as eight 32-bit words. A done pulse reports the hit or miss.

The same byte stream also carries the join and leave commands. The command code is sampled with the first byte. When the address completes, the block computes the index itself and then sets or clears the matching table bit. A small register port lets software read any table word and overwrite it whole.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset, all eight table words read as zero and `match_done` is low.
- R2: The CRC register is preset to all ones when a byte arrives with `in_start`. It then steps through exactly six accepted bytes in arrival order, each byte least significant bit first, using the reflected polynomial 0xEDB88320. No final inversion is applied. The 32-bit result is bit-reversed, and its top 8 bits form the hash index.
- R3: Index bits [7:5] select table word 0..7. Index bits [4:0] = n select bit (31 − n) of that word. Entry 0 is therefore bit 31 of word 0, and entry 255 is bit 0 of word 7.
- R4: `match_done` is high for exactly one cycle, the cycle after the sixth byte is accepted. In that cycle `match_hit` equals the addressed table bit as it stood before any update caused by this address.
- R5: Op code 1 (join) sets the addressed bit at the clock edge that ends the done cycle. All other table bits keep their values.
- R6: Op code 2 (leave) clears the addressed bit at that same edge. All other table bits keep their values.
- R7: Op code 0 or 3 (lookup) leaves every table word unchanged.
- R8: When `tbl_we` is high, the word selected by `tbl_sel` is replaced by `tbl_wdata` at the clock edge. `tbl_rdata` always shows the word selected by `tbl_sel`, with no delay.
- R9: A byte accepted with `in_start` abandons any address in progress and restarts the count and the CRC. Bytes with `in_valid` high but no preceding start are ignored: they produce no done pulse and change no table word.
- R10: If a register write and a join or leave hit the same word in the same cycle, the written word is taken and then the addressed bit is set or cleared on top of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_start | input | 1 | Marks the first address byte; only valid together with `in_valid` |
| in_valid | input | 1 | Address byte present on `in_byte` this cycle |
| in_byte | input | 8 | Destination-address byte, first transmitted byte first |
| in_op | input | 2 | Command sampled with the first byte: 0 lookup, 1 join, 2 leave, 3 lookup |
| match_hit | output | 1 | Table bit for the completed address, valid while `match_done` is high |
| match_done | output | 1 | One-cycle pulse after the sixth byte |
| tbl_we | input | 1 | Table word write enable |
| tbl_sel | input | 3 | Table word select for read and write |
| tbl_wdata | input | 32 | Table word write data |
| tbl_rdata | output | 32 | Selected table word |

## Verification
The assertions assume that `in_start` is only raised together with `in_valid`, and that an address, once started, delivers its six bytes on consecutive cycles. Under those conditions two done pulses are always at least six cycles apart. The stimulus meets both conditions by driving every address from one task that presents the bytes back to back with the start strobe on the first byte only. The only exceptions are the deliberate restart and the stray-byte cases, and both of those still raise start only with valid.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

    localparam int BYTE_W     = 8;
    localparam int CRC_W      = 32;
    localparam int ADDR_BYTES = 6;
    localparam int WORD_W     = 32;
    localparam int NUM_WORDS  = 8;
    localparam int SEL_W      = $clog2(NUM_WORDS);
    localparam int BIT_W      = $clog2(WORD_W);
    localparam int IDX_W      = SEL_W + BIT_W;
    localparam int CNT_W      = $clog2(ADDR_BYTES + 1);

    localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;

    typedef enum logic [1:0] {
        OP_LOOK  = 2'd0,
        OP_JOIN  = 2'd1,
        OP_LEAVE = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [BIT_W-1:0] pos;
    } idx_t;

    typedef struct packed {
        logic valid;
        op_e  op;
        idx_t idx;
    } result_t;

    // One byte through the reflected CRC, low bit first.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic [BYTE_W-1:0] b);
        logic [CRC_W-1:0] r;
        r = c ^ {{(CRC_W-BYTE_W){1'b0}}, b};
        for (int i = 0; i < BYTE_W; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

    function automatic logic [CRC_W-1:0] bit_reverse(input logic [CRC_W-1:0] v);
        logic [CRC_W-1:0] r;
        for (int i = 0; i < CRC_W; i++) begin
            r[i] = v[CRC_W-1-i];
        end
        return r;
    endfunction

    function automatic idx_t crc_to_index(input logic [CRC_W-1:0] c);
        logic [CRC_W-1:0] rv;
        rv = bit_reverse(c);
        return idx_t'(rv[CRC_W-1 -: IDX_W]);
    endfunction

endpackage

// File: rtl/mhf_crc_unit.sv
module mhf_crc_unit
    import mhf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_start,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic [1:0]        in_op,
    output result_t           res
);

    logic [CRC_W-1:0] crc_q;
    logic [CNT_W-1:0] cnt_q;
    logic             active_q;
    logic             fin_q;
    op_e              op_q;

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ADDR_BYTES - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q    <= '1;
            cnt_q    <= '0;
            active_q <= 1'b0;
            fin_q    <= 1'b0;
            op_q     <= OP_LOOK;
        end else begin
            fin_q <= 1'b0;
            if (in_valid && in_start) begin
                crc_q    <= crc_step('1, in_byte);
                cnt_q    <= CNT_W'(1);
                op_q     <= op_e'(in_op);
                active_q <= 1'b1;
            end else if (in_valid && active_q) begin
                crc_q <= crc_step(crc_q, in_byte);
                if (cnt_q == LAST_CNT) begin
                    cnt_q    <= '0;
                    active_q <= 1'b0;
                    fin_q    <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end

    always_comb begin
        res.valid = fin_q;
        res.op    = op_q;
        res.idx   = crc_to_index(crc_q);
    end

    AST_START_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        in_start |-> in_valid);                                        // R9
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        fin_q |=> !fin_q);                                             // R4
    AST_DONE_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
        $rose(fin_q) |-> ($past(in_valid) && !$past(in_start)));       // R4

endmodule

// File: rtl/mhf_table.sv
module mhf_table
    import mhf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  result_t           res,
    input  logic              tbl_we,
    input  logic [SEL_W-1:0]  tbl_sel,
    input  logic [WORD_W-1:0] tbl_wdata,
    output logic [WORD_W-1:0] tbl_rdata,
    output logic              hit
);

    logic [WORD_W-1:0] words_q [NUM_WORDS];
    logic [WORD_W-1:0] words_d [NUM_WORDS];
    logic [BIT_W-1:0]  bitnum;
    logic              do_set;
    logic              do_clr;

    // Entries are numbered from the most significant bit downward.
    assign bitnum = BIT_W'(WORD_W - 1) - res.idx.pos;
    assign do_set = res.valid && (res.op == OP_JOIN);
    assign do_clr = res.valid && (res.op == OP_LEAVE);

    always_comb begin
        for (int w = 0; w < NUM_WORDS; w++) begin
            words_d[w] = (tbl_we && tbl_sel == SEL_W'(w)) ? tbl_wdata : words_q[w];
            if (res.idx.sel == SEL_W'(w)) begin
                if (do_set) words_d[w][bitnum] = 1'b1;
                if (do_clr) words_d[w][bitnum] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (rst) words_q[w] <= '0;
            else     words_q[w] <= words_d[w];
        end
    end

    assign tbl_rdata = words_q[tbl_sel];
    assign hit       = words_q[res.idx.sel][bitnum];

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_chk
        AST_RESET_CLEAR: assert property (@(posedge clk)
            rst |=> (words_q[g] == '0));                               // R1
        AST_JOIN_SETS: assert property (@(posedge clk) disable iff (rst)
            (do_set && res.idx.sel == SEL_W'(g)) |=> words_q[g][$past(bitnum)]);  // R5
        AST_LEAVE_CLEARS: assert property (@(posedge clk) disable iff (rst)
            (do_clr && res.idx.sel == SEL_W'(g)) |=> !words_q[g][$past(bitnum)]); // R6
        AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
            (!(tbl_we && tbl_sel == SEL_W'(g)) &&
             !((do_set || do_clr) && res.idx.sel == SEL_W'(g)))
            |=> $stable(words_q[g]));                                  // R7
        AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
            (tbl_we && tbl_sel == SEL_W'(g) && !res.valid)
            |=> (words_q[g] == $past(tbl_wdata)));                     // R8
    end

endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter
    import mhf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_start,
    input  logic        in_valid,
    input  logic [7:0]  in_byte,
    input  logic [1:0]  in_op,
    output logic        match_hit,
    output logic        match_done,
    input  logic        tbl_we,
    input  logic [2:0]  tbl_sel,
    input  logic [31:0] tbl_wdata,
    output logic [31:0] tbl_rdata
);

    result_t res;
    logic    hit_raw;

    mhf_crc_unit u_crc (
        .clk      (clk),
        .rst      (rst),
        .in_start (in_start),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .in_op    (in_op),
        .res      (res)
    );

    mhf_table u_tbl (
        .clk       (clk),
        .rst       (rst),
        .res       (res),
        .tbl_we    (tbl_we),
        .tbl_sel   (tbl_sel),
        .tbl_wdata (tbl_wdata),
        .tbl_rdata (tbl_rdata),
        .hit       (hit_raw)
    );

    assign match_done = res.valid;
    assign match_hit  = res.valid & hit_raw;

    AST_HIT_ONLY_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        match_hit |-> match_done);                                     // R4

endmodule

// File: tb/mcast_hash_filter_test.sv
`timescale 1ns/1ps
module mcast_hash_filter_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_start, in_valid;
    logic [7:0]  in_byte;
    logic [1:0]  in_op;
    logic        match_hit, match_done;
    logic        tbl_we;
    logic [2:0]  tbl_sel;
    logic [31:0] tbl_wdata, tbl_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] mdl [8];

    always #10 clk = ~clk;

    mcast_hash_filter uut (
        .clk(clk), .rst(rst), .in_start(in_start), .in_valid(in_valid),
        .in_byte(in_byte), .in_op(in_op), .match_hit(match_hit),
        .match_done(match_done), .tbl_we(tbl_we), .tbl_sel(tbl_sel),
        .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_index(input logic [47:0] a);
        logic [31:0] c, r;
        c = 32'hFFFF_FFFF;
        for (int k = 0; k < 6; k++) begin
            c ^= {24'h0, a[47-8*k -: 8]};
            for (int i = 0; i < 8; i++)
                c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        for (int i = 0; i < 32; i++) r[i] = c[31-i];
        return r[31:24];
    endfunction

    task automatic read_chk(input int w, input string req);
        @(negedge clk);
        tbl_sel = 3'(w);
        #1;
        chk(tbl_rdata === mdl[w], req, tbl_rdata, mdl[w]);
    endtask

    task automatic reg_write(input int w, input logic [31:0] v);
        @(negedge clk);
        tbl_we = 1'b1; tbl_sel = 3'(w); tbl_wdata = v;
        @(negedge clk);
        tbl_we = 1'b0;
        mdl[w] = v;
    endtask

    task automatic do_addr(input logic [1:0] op, input logic [47:0] a,
                           input bit wr_same, input logic [31:0] wv, input string req);
        logic [7:0] idx;
        int w, bn;
        idx = ref_index(a);
        w   = int'(idx[7:5]);
        bn  = 31 - int'(idx[4:0]);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_start = (k == 0); in_byte = a[47-8*k -: 8]; in_op = op;
        end
        @(negedge clk);
        in_valid = 1'b0; in_start = 1'b0;
        if (wr_same) begin
            tbl_we = 1'b1; tbl_sel = 3'(w); tbl_wdata = wv;
        end
        #1;
        chk(match_done === 1'b1, {req, " done"}, 32'(match_done), 32'd1);
        chk(match_hit === mdl[w][bn], {req, " hit"}, 32'(match_hit), 32'(mdl[w][bn]));
        @(negedge clk);
        tbl_we = 1'b0;
        if (wr_same) mdl[w] = wv;
        if (op == 2'd1) mdl[w][bn] = 1'b1;
        if (op == 2'd2) mdl[w][bn] = 1'b0;
        chk(match_done === 1'b0, "R4 pulse width", 32'(match_done), 32'd0);
        tbl_sel = 3'(w);
        #1;
        chk(tbl_rdata === mdl[w], {req, " word"}, tbl_rdata, mdl[w]);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [47:0] pool [8];
        logic [47:0] a;
        logic [7:0]  ix;
        void'($urandom(32'h1234));
        rst = 1'b1; in_start = 0; in_valid = 0; in_byte = 0; in_op = 0;
        tbl_we = 0; tbl_sel = 0; tbl_wdata = 0;
        for (int w = 0; w < 8; w++) mdl[w] = 32'h0;
        for (int i = 0; i < 8; i++) pool[i] = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF | 48'h0100_0000_0000;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        chk(match_done === 1'b0, "R1 done after reset", 32'(match_done), 32'd0);
        for (int w = 0; w < 8; w++) read_chk(w, "R1 reset word");

        // R3/R5: join places exactly the MSB-first bit.
        a = pool[0];
        ix = ref_index(a);
        do_addr(2'd1, a, 1'b0, 32'h0, "R5 join");
        chk(mdl[ix[7:5]] === (32'h8000_0000 >> ix[4:0]), "R3 mapping",
            mdl[ix[7:5]], 32'h8000_0000 >> ix[4:0]);
        do_addr(2'd0, a, 1'b0, 32'h0, "R2 lookup hit");
        do_addr(2'd2, a, 1'b0, 32'h0, "R6 leave");
        do_addr(2'd3, a, 1'b0, 32'h0, "R7 lookup miss");

        // R8: word write then lookup.
        reg_write(int'(ix[7:5]), 32'hFFFF_FFFF);
        read_chk(int'(ix[7:5]), "R8 readback");
        do_addr(2'd0, a, 1'b0, 32'h0, "R8 written hit");
        reg_write(int'(ix[7:5]), 32'h0);

        // R10: same-cycle write and join.
        do_addr(2'd1, pool[1], 1'b1, 32'h0F0F_0F0F, "R10 write+join");
        do_addr(2'd2, pool[1], 1'b1, 32'hFFFF_FFFF, "R10 write+leave");

        // R9: restart mid-address, then stray bytes.
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_start = (k == 0); in_byte = pool[3][47-8*k -: 8]; in_op = 2'd1;
        end
        do_addr(2'd1, pool[2], 1'b0, 32'h0, "R9 restart");
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_start = 1'b0; in_byte = 8'(k * 37); in_op = 2'd1;
            #1;
            chk(match_done === 1'b0, "R9 stray bytes", 32'(match_done), 32'd0);
        end
        @(negedge clk); in_valid = 1'b0;
        #1;
        chk(match_done === 1'b0, "R9 stray bytes", 32'(match_done), 32'd0);
        for (int w = 0; w < 8; w++) read_chk(w, "R9 table unchanged");

        // Random mix over a small address pool.
        for (int it = 0; it < 80; it++) begin
            int r;
            r = int'($urandom % 10);
            if (r == 0) reg_write(int'($urandom % 8), $urandom);
            else do_addr(2'($urandom % 4), pool[$urandom % 8], ($urandom % 8) == 0,
                         $urandom, "R2 random");
        end
        for (int w = 0; w < 8; w++) read_chk(w, "R8 final word");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule